// File: doc/BRIEF.md
# Five-Source Bus Master Arbiter

This block decides which of five internal requesters may start the next PCI master transaction. Four of them are DMA FIFO engines (transmit 0, transmit 1, receive 0, receive 1). The fifth is a single quad-word access path. That path always wins, whatever the mode.

A two-bit mode input picks the scheme for the four FIFO engines:
- round robin;
- programmable priority;
- customized, where logic outside the block chooses the winner. The block shows the pending requests on a four-bit vector, and the outside logic answers on an encoded two-bit select.

The block registers a one-hot grant and raises a valid flag. It holds the grant until a bus-release pulse says the owner's transaction is over, and it arbitrates again only while no grant is held.

Top module: `pciMasterArb`

## Requirements
- R1: After reset `grantValid` is 0, `grant` is all zero and the round-robin pointer points at T0.
- R2: When `singleReq` is high and no grant is held, the next grant goes to the single-access path (`grant` bit 4) in every mode, whatever the FIFO requests are.
- R3: `mode` is decoded as 2'b00 round robin, 2'b01 priority, 2'b10 customized; 2'b11 behaves exactly like round robin.
- R4: In round robin the search starts at the pointer and visits T0, T1, R0, R1 and wraps around, skipping requesters that are not requesting. After every FIFO grant, in any mode, the pointer moves to the requester after the one granted.
- R5: In priority mode the requesting FIFO with the largest value in `prio` wins. Field i is `prio[i*PRIO_W +: PRIO_W]`, with i = 0 T0, 1 T1, 2 R0, 3 R1. On a tie the lower i wins.
- R6: In customized mode `extReq` bit 3 = T0, bit 2 = T1, bit 1 = R0 and bit 0 = R1. In the other modes `extReq` is zero.
- R7: In customized mode the winner is given by `extSel`: 2'b00 R1, 2'b01 R0, 2'b10 T1, 2'b11 T0.
- R8: In customized mode, a select that names a FIFO with no pending request gives no grant.
- R9: `grant` is one-hot with bit 0 T0, bit 1 T1, bit 2 R0, bit 3 R1 and bit 4 the single-access path. `grantValid` is high exactly when `grant` is nonzero. A grant goes only to a source that was requesting.
- R10: A grant is held unchanged, and request changes are ignored, until a cycle with `busRelease` high. That edge clears the grant, and arbitration resumes on the following edge.
- R11: With no request pending, no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Arbitration scheme select |
| singleReq | input | 1 | Single-access path request |
| fifoReq | input | 4 | FIFO requests, bit 0 T0 .. bit 3 R1 |
| prio | input | 4*PRIO_W | Per-FIFO priority values |
| busRelease | input | 1 | Pulse at the end of the owner's transaction |
| extSel | input | 2 | Winner chosen by outside logic (customized mode) |
| extReq | output | 4 | Request vector shown to outside logic |
| grant | output | 5 | One-hot registered grant |
| grantValid | output | 1 | A grant is held |

## Verification
The bench builds the arbiter with the default `PRIO_W` of 2. That value makes all four priority levels reachable, including ties at the top level and the all-zero case. The table is walked in an order in which the round-robin pointer is carried over from one entry to the next, so that pointer moves caused by priority and customized grants also feed into later round-robin results. Directed tests cover the hold-until-release behaviour and the reset state.

// File: rtl/arbPkg.sv
package arbPkg;
  localparam int NUM_FIFO = 4;
  localparam int IDX_W    = $clog2(NUM_FIFO);
  localparam int NUM_SRC  = NUM_FIFO + 1;
  localparam int SINGLE_BIT = NUM_FIFO;

  typedef enum logic [1:0] {
    MODE_RR     = 2'b00,
    MODE_PRIO   = 2'b01,
    MODE_CUSTOM = 2'b10,
    MODE_RSVD   = 2'b11
  } arbMode_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_OWNED = 1'b1
  } arbState_t;

  typedef struct packed {
    logic loadGrant;
    logic clearGrant;
  } arbStrobes_t;
endpackage

// File: rtl/arbCtrl.sv
module arbCtrl
  import arbPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        winValid,
  input  logic        busRelease,
  output arbStrobes_t strobes
);
  arbState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    case (state)
      ST_IDLE: begin
        if (winValid) begin
          strobes.loadGrant = 1'b1;
          stateNext = ST_OWNED;
        end
      end
      ST_OWNED: begin
        if (busRelease) begin
          strobes.clearGrant = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/arbDatapath.sv
module arbDatapath
  import arbPkg::*;
#(
  parameter int PRIO_W = 2
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 mode,
  input  logic                       singleReq,
  input  logic [NUM_FIFO-1:0]        fifoReq,
  input  logic [NUM_FIFO*PRIO_W-1:0] prio,
  input  logic [1:0]                 extSel,
  input  arbStrobes_t                strobes,
  output logic                       winValid,
  output logic [NUM_FIFO-1:0]        extReq,
  output logic [NUM_SRC-1:0]         grant
);
  logic [IDX_W-1:0]  rrPtr;
  logic [IDX_W-1:0]  rrIdx, prioIdx, custIdx, fifoIdx;
  logic              rrHit, prioHit, custHit, fifoHit;
  logic [PRIO_W-1:0] bestPrio;
  logic [NUM_SRC-1:0] winOneHot;
  logic              isCustom;

  assign isCustom = (arbMode_t'(mode) == MODE_CUSTOM);

  // request vector for outside logic, order reversed
  genvar g;
  generate
    for (g = 0; g < NUM_FIFO; g++) begin : gExtReq
      assign extReq[NUM_FIFO-1-g] = isCustom & fifoReq[g];
    end
  endgenerate

  // round robin search starting at the pointer
  always_comb begin
    rrHit = 1'b0;
    rrIdx = '0;
    for (int k = 0; k < NUM_FIFO; k++) begin
      logic [IDX_W-1:0] cand;
      cand = rrPtr + IDX_W'(k);
      if (!rrHit && fifoReq[cand]) begin
        rrHit = 1'b1;
        rrIdx = cand;
      end
    end
  end

  // priority search, strict compare keeps the lower index on ties
  always_comb begin
    prioHit  = 1'b0;
    prioIdx  = '0;
    bestPrio = '0;
    for (int i = 0; i < NUM_FIFO; i++) begin
      if (fifoReq[i] && (!prioHit || prio[i*PRIO_W +: PRIO_W] > bestPrio)) begin
        prioHit  = 1'b1;
        prioIdx  = IDX_W'(i);
        bestPrio = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end

  // external select: code 0 names the last FIFO
  assign custIdx = IDX_W'(NUM_FIFO-1) - IDX_W'(extSel);
  assign custHit = fifoReq[custIdx];

  always_comb begin
    case (arbMode_t'(mode))
      MODE_PRIO:   begin fifoHit = prioHit; fifoIdx = prioIdx; end
      MODE_CUSTOM: begin fifoHit = custHit; fifoIdx = custIdx; end
      default:     begin fifoHit = rrHit;   fifoIdx = rrIdx;   end
    endcase
  end

  always_comb begin
    winOneHot = '0;
    if (singleReq)    winOneHot[SINGLE_BIT] = 1'b1;
    else if (fifoHit) winOneHot[fifoIdx]    = 1'b1;
  end

  assign winValid = singleReq | fifoHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grant <= '0;
      rrPtr <= '0;
    end else begin
      if (strobes.loadGrant) begin
        grant <= winOneHot;
        if (!singleReq) rrPtr <= fifoIdx + IDX_W'(1);
      end else if (strobes.clearGrant) begin
        grant <= '0;
      end
    end
  end
endmodule

// File: rtl/pciMasterArb.sv
module pciMasterArb #(
  parameter int PRIO_W = 2
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            mode,
  input  logic                  singleReq,
  input  logic [3:0]            fifoReq,
  input  logic [4*PRIO_W-1:0]   prio,
  input  logic                  busRelease,
  input  logic [1:0]            extSel,
  output logic [3:0]            extReq,
  output logic [4:0]            grant,
  output logic                  grantValid
);
  arbPkg::arbStrobes_t strobes;
  logic winValid;

  arbCtrl uCtrl (
    .clk(clk), .rstN(rstN), .winValid(winValid),
    .busRelease(busRelease), .strobes(strobes)
  );

  arbDatapath #(.PRIO_W(PRIO_W)) uDp (
    .clk(clk), .rstN(rstN), .mode(mode), .singleReq(singleReq),
    .fifoReq(fifoReq), .prio(prio), .extSel(extSel), .strobes(strobes),
    .winValid(winValid), .extReq(extReq), .grant(grant)
  );

  assign grantValid = |grant;
endmodule

// File: rtl/arbChk.sv
module arbChk #(
  parameter int PRIO_W = 2
)(
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          mode,
  input logic                singleReq,
  input logic [3:0]          fifoReq,
  input logic [4*PRIO_W-1:0] prio,
  input logic                busRelease,
  input logic [1:0]          extSel,
  input logic [3:0]          extReq,
  input logic [4:0]          grant,
  input logic                grantValid
);
  logic [1:0] selIdx;
  assign selIdx = 2'd3 - extSel;

  // R9
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> $onehot(grant));

  // R9
  granted_requester_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantValid) |-> ($past(singleReq) ? grant[4] : |(grant[3:0] & $past(fifoReq))));

  // R2
  single_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!grantValid && singleReq) |=> grant[4]);

  // R10
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !busRelease) |=> (grantValid && $stable(grant)));

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && busRelease) |=> !grantValid);

  // R8
  bad_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!grantValid && mode == 2'b10 && !singleReq && !fifoReq[selIdx]) |=> !grantValid);

  // R6
  ext_req_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10) |-> (extReq == {fifoReq[0], fifoReq[1], fifoReq[2], fifoReq[3]}));

  // R11
  no_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!grantValid && !singleReq && fifoReq == 4'b0) |=> !grantValid);
endmodule

bind pciMasterArb arbChk #(.PRIO_W(PRIO_W)) uChk (
  .clk(clk), .rstN(rstN), .mode(mode), .singleReq(singleReq),
  .fifoReq(fifoReq), .prio(prio), .busRelease(busRelease), .extSel(extSel),
  .extReq(extReq), .grant(grant), .grantValid(grantValid)
);

// File: tb/sim_pciMasterArb.sv
module sim_pciMasterArb;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] mode;
  logic       singleReq;
  logic [3:0] fifoReq;
  logic [7:0] prio;
  logic       busRelease;
  logic [1:0] extSel;
  logic [3:0] extReq;
  logic [4:0] grant;
  logic       grantValid;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pciMasterArb #(.PRIO_W(2)) u0 (
    .clk(clk), .rstN(rstN), .mode(mode), .singleReq(singleReq),
    .fifoReq(fifoReq), .prio(prio), .busRelease(busRelease), .extSel(extSel),
    .extReq(extReq), .grant(grant), .grantValid(grantValid)
  );

  // {tag, mode, single, req, prio, sel, expGrant}
  typedef struct packed {
    logic [7:0] tag;
    logic [1:0] md;
    logic       sgl;
    logic [3:0] req;
    logic [7:0] pr;
    logic [1:0] sel;
    logic [4:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'd4,  2'b00, 1'b0, 4'b1111, 8'h00, 2'b00, 5'b00001}, // R4 T0 first
    '{8'd4,  2'b00, 1'b0, 4'b1111, 8'h00, 2'b00, 5'b00010}, // R4 T1 next
    '{8'd4,  2'b00, 1'b0, 4'b1011, 8'h00, 2'b00, 5'b01000}, // R4 skip R0
    '{8'd3,  2'b11, 1'b0, 4'b0110, 8'h00, 2'b00, 5'b00010}, // R3 reserved = RR, wrapped
    '{8'd5,  2'b01, 1'b0, 4'b1111, 8'hF9, 2'b00, 5'b00100}, // R5 tie R0/R1 -> R0
    '{8'd5,  2'b01, 1'b0, 4'b1001, 8'h00, 2'b00, 5'b00001}, // R5 all zero -> T0
    '{8'd2,  2'b01, 1'b1, 4'b1111, 8'hFF, 2'b00, 5'b10000}, // R2 single wins
    '{8'd7,  2'b10, 1'b0, 4'b1111, 8'h00, 2'b00, 5'b01000}, // R7 sel 00 -> R1
    '{8'd7,  2'b10, 1'b0, 4'b1111, 8'h00, 2'b11, 5'b00001}, // R7 sel 11 -> T0
    '{8'd7,  2'b10, 1'b0, 4'b0100, 8'h00, 2'b01, 5'b00100}, // R7 sel 01 -> R0
    '{8'd8,  2'b10, 1'b0, 4'b1101, 8'h00, 2'b10, 5'b00000}, // R8 T1 idle
    '{8'd11, 2'b00, 1'b0, 4'b0000, 8'h00, 2'b00, 5'b00000}, // R11 nothing
    '{8'd4,  2'b00, 1'b0, 4'b1111, 8'h00, 2'b00, 5'b01000}, // R4 pointer from custom grant
    '{8'd2,  2'b00, 1'b1, 4'b0000, 8'h00, 2'b00, 5'b10000}  // R2 single alone
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic releaseBus();
    busRelease = 1'b1;
    singleReq = 1'b0;
    fifoReq = 4'b0;
    @(posedge clk);
    @(negedge clk);
    busRelease = 1'b0;
  endtask

  initial begin : watchdog
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog timeout");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; mode = 2'b00; singleReq = 1'b0; fifoReq = 4'b0;
    prio = 8'h00; busRelease = 1'b0; extSel = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 grant", {27'b0, grant}, 32'h0);
    check("R1 grantValid", {31'b0, grantValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[v].tag, v);
      mode = VECS[v].md; singleReq = VECS[v].sgl; fifoReq = VECS[v].req;
      prio = VECS[v].pr; extSel = VECS[v].sel;
      #1;
      // R6 request vector mapping
      check($sformatf("R6 vec%0d", v), {28'b0, extReq},
            {28'b0, (VECS[v].md == 2'b10) ?
              {VECS[v].req[0], VECS[v].req[1], VECS[v].req[2], VECS[v].req[3]} : 4'b0});
      @(posedge clk);
      @(negedge clk);
      check(tag, {27'b0, grant}, {27'b0, VECS[v].exp});
      check($sformatf("R9 vec%0d", v), {31'b0, grantValid}, {31'b0, |VECS[v].exp});
      releaseBus();
    end

    // R10 hold: grant T0 then change requests, grant must stay
    mode = 2'b01; prio = 8'h00; fifoReq = 4'b0001;
    @(posedge clk); @(negedge clk);
    check("R10 first grant", {27'b0, grant}, 32'h1);
    singleReq = 1'b1; fifoReq = 4'b1110; prio = 8'hFC;
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      check("R10 held", {27'b0, grant}, 32'h1);
    end
    busRelease = 1'b1;
    @(posedge clk); @(negedge clk);
    busRelease = 1'b0;
    check("R10 cleared", {31'b0, grantValid}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R10 rearbitrate R2 single", {27'b0, grant}, 32'h10);
    releaseBus();

    // R1 pointer after reset starts at T0
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    rstN = 1'b1; mode = 2'b00; fifoReq = 4'b1111;
    @(posedge clk); @(negedge clk);
    check("R1 pointer at T0", {27'b0, grant}, 32'h1);
    releaseBus();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule